// File: doc/BRIEF.md
# Write-Through Word Cache

This block sits between a processor's load/store port and a word-wide memory port. It keeps a direct-mapped copy of recently used words. Each line holds one word, and the default store has 1024 lines. A read that hits returns the addressed word, byte or halfword without touching memory. A read that misses fetches the aligned word over the memory handshake, stores it and returns the requested part. Only two 1 MB address windows are cached. Every other address is passed straight through to memory.

Every store is written through to memory. A full-word store to a cached window also refreshes the line with the new word and its tag. A byte or halfword store drops the line instead of merging into it. The processor holds its request until `cpu_ready` pulses. After reset the block clears all tags, one line per cycle, before it accepts the first request.

Top module: `wt_line_cache`

## Requirements
- R1: After reset, the block spends one cycle per line clearing the tag store and raises no `cpu_ready` during that time. A request held from the end of reset completes only after the sweep, and it misses.
- R2: An address is cacheable only when its bits [31:20] equal 0x100 or 0x101. Reads of any other address, such as 0x200 or 0x102 in those bits, go to memory every time.
- R3: A read miss issues a memory read of the word-aligned address (`mem_addr[1:0]` = 0, `mem_be` = 4'b1111, `mem_we` = 0) and installs the word. A repeated read of the same word then hits without a memory access.
- R4: The line index is address bits [11:2] and the stored tag is bits [20:12]. Two cacheable addresses with the same index but different tags evict each other.
- R5: A stored tag of all ones (0x1FF) means the line is empty. A cacheable address whose bits [20:12] are all ones therefore never hits.
- R6: Sub-word reads use big-endian lanes and are zero-extended in `cpu_rdata`. `cpu_size` 0 selects a byte, where offset k takes bits [31-8k:24-8k]. `cpu_size` 1 selects a halfword, where offset 0 takes [31:16] and offset 2 takes [15:0]. `cpu_size` 2 or 3 selects the full word.
- R7: Every write reaches memory with `mem_we` = 1 and a word-aligned `mem_addr`. The data is replicated across the lanes. The byte enables follow the same lane order: `mem_be` bit 3 is bits [31:24]. A byte at offset k enables bit 3-k, a halfword at offset 0 gives 4'b1100, and a halfword at offset 2 gives 4'b0011.
- R8: A word write to a cacheable address installs that word, even if the line held something else. A following read of it hits and returns the written data.
- R9: A byte or halfword write to a cacheable address empties that line. The next read of the word misses and returns memory's merged contents.
- R10: `cpu_ready` is a one-cycle pulse. `mem_req` and its fields stay stable until `mem_ack`. A read hit completes two cycles after the request is first sampled. A miss completes in two cycles plus the memory latency.
- R11: A write to an address outside the cacheable windows leaves the cache untouched, even when its index and tag bits match a cached line.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cpu_req | input | 1 | Processor request, held until `cpu_ready` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_size | input | 2 | 0 byte, 1 halfword, 2/3 word |
| cpu_addr | input | 32 | Byte address |
| cpu_wdata | input | 32 | Store data, right-aligned for sub-word stores |
| cpu_ready | output | 1 | One-cycle completion pulse |
| cpu_rdata | output | 32 | Load result, zero-extended |
| mem_req | output | 1 | Memory request, held until `mem_ack` |
| mem_we | output | 1 | Memory write |
| mem_addr | output | 32 | Word-aligned memory address |
| mem_be | output | 4 | Byte enables, bit 3 = bits [31:24] |
| mem_wdata | output | 32 | Lane-replicated write data |
| mem_ack | input | 1 | Memory completion |
| mem_rdata | input | 32 | Memory read word, valid with `mem_ack` |

## Verification
The write-through to memory and the change to the line's own entry happen together. They share the edge on which `mem_ack` completes the store, and `cpu_ready` pulses on that same edge. The bench provokes this by issuing a store and then, in the very next request, a load of the same word. This is done for a word store, for a byte store and for a halfword store into a line that was just installed. The word case must hit with the new data and no memory traffic. The sub-word cases must miss and return memory's merged word, never the stale cached copy. A request held across the end of reset also overlaps the tag-clearing sweep. It is judged by its exact completion cycle and by being a miss.

// File: rtl/wtc_pkg.sv
package wtc_pkg;
  typedef enum logic [1:0] {
    SZ_BYTE     = 2'd0,
    SZ_HALF     = 2'd1,
    SZ_WORD     = 2'd2,
    SZ_WORD_ALT = 2'd3
  } size_e;

  typedef enum logic [1:0] {
    ST_INIT,
    ST_IDLE,
    ST_LOOK,
    ST_MEM
  } state_e;
endpackage

// File: rtl/wtc_region.sv
// Decides whether the top address bits fall in one of the cached windows.
module wtc_region #(
  parameter int              REGION_W = 12,
  parameter logic [REGION_W-1:0] WIN_A = 12'h100,
  parameter logic [REGION_W-1:0] WIN_B = 12'h101
) (
  input  logic [REGION_W-1:0] page,
  output logic                cacheable
);
  assign cacheable = (page == WIN_A) || (page == WIN_B);
endmodule

// File: rtl/wtc_store.sv
// Tag and data arrays: one write port, one synchronous read port (block RAM style).
module wtc_store #(
  parameter int INDEX_W = 10,
  parameter int TAG_W   = 9,
  parameter int DATA_W  = 32
) (
  input  logic               clk,
  input  logic               tag_we,
  input  logic               data_we,
  input  logic [INDEX_W-1:0] widx,
  input  logic [TAG_W-1:0]   wtag,
  input  logic [DATA_W-1:0]  wdata,
  input  logic [INDEX_W-1:0] ridx,
  output logic [TAG_W-1:0]   rtag,
  output logic [DATA_W-1:0]  rdata
);
  localparam int DEPTH = 1 << INDEX_W;

  logic [TAG_W-1:0]  tag_mem  [DEPTH];
  logic [DATA_W-1:0] data_mem [DEPTH];

  always_ff @(posedge clk) begin
    if (tag_we)  tag_mem[widx]  <= wtag;
    if (data_we) data_mem[widx] <= wdata;
    rtag  <= tag_mem[ridx];
    rdata <= data_mem[ridx];
  end
endmodule

// File: rtl/wtc_lanes.sv
// Big-endian lane select for loads; enables and replication for stores.
module wtc_lanes
  import wtc_pkg::*;
#(
  parameter int DATA_W = 32,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES)
) (
  input  logic [DATA_W-1:0] word_in,
  input  logic [OFF_W-1:0]  off,
  input  size_e             size,
  input  logic [DATA_W-1:0] st_data,
  output logic [DATA_W-1:0] ld_lane,
  output logic [LANES-1:0]  st_be,
  output logic [DATA_W-1:0] st_rep
);
  logic [OFF_W-1:0] byte_lane;
  logic [OFF_W-2:0] half_lane;

  assign byte_lane = ~off;
  assign half_lane = ~off[OFF_W-1:1];

  always_comb begin
    case (size)
      SZ_BYTE: begin
        ld_lane = (word_in >> {byte_lane, 3'b000}) & DATA_W'(8'hFF);
        st_be   = LANES'(1) << byte_lane;
        st_rep  = {LANES{st_data[7:0]}};
      end
      SZ_HALF: begin
        ld_lane = (word_in >> {half_lane, 4'b0000}) & DATA_W'(16'hFFFF);
        st_be   = LANES'(3) << {half_lane, 1'b0};
        st_rep  = {(LANES/2){st_data[15:0]}};
      end
      default: begin
        ld_lane = word_in;
        st_be   = '1;
        st_rep  = st_data;
      end
    endcase
  end
endmodule

// File: rtl/wt_line_cache.sv
module wt_line_cache
  import wtc_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int DATA_W   = 32,
  parameter int INDEX_W  = 10,
  parameter int TAG_W    = 9,
  parameter int REGION_W = 12,
  parameter logic [REGION_W-1:0] WIN_A = 12'h100,
  parameter logic [REGION_W-1:0] WIN_B = 12'h101
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [1:0]        cpu_size,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic              cpu_ready,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W/8-1:0] mem_be,
  output logic [DATA_W-1:0] mem_wdata,
  input  logic              mem_ack,
  input  logic [DATA_W-1:0] mem_rdata
);
  localparam int LANES   = DATA_W / 8;
  localparam int OFF_W   = $clog2(LANES);
  localparam int IDX_LSB = OFF_W;
  localparam int TAG_LSB = IDX_LSB + INDEX_W;
  localparam int DEPTH   = 1 << INDEX_W;
  localparam logic [TAG_W-1:0] EMPTY_TAG = '1;

  state_e              state_q;
  logic [INDEX_W-1:0]  sweep_q;
  logic [ADDR_W-1:0]   req_addr_q;
  logic                req_we_q;
  logic [1:0]          req_size_q;
  logic [DATA_W-1:0]   req_wdata_q;

  logic [INDEX_W-1:0]  req_idx;
  logic [TAG_W-1:0]    req_tag;
  logic                cacheable;
  logic                hit;

  logic                tag_we, data_we;
  logic [INDEX_W-1:0]  widx;
  logic [TAG_W-1:0]    wtag;
  logic [DATA_W-1:0]   wdata;
  logic [TAG_W-1:0]    rd_tag;
  logic [DATA_W-1:0]   rd_data;

  logic [DATA_W-1:0]   lane_src, ld_lane, st_rep;
  logic [LANES-1:0]    st_be;

  assign req_idx = req_addr_q[IDX_LSB +: INDEX_W];
  assign req_tag = req_addr_q[TAG_LSB +: TAG_W];

  wtc_region #(.REGION_W(REGION_W), .WIN_A(WIN_A), .WIN_B(WIN_B)) u_region (
    .page      (req_addr_q[ADDR_W-1 -: REGION_W]),
    .cacheable (cacheable)
  );

  wtc_store #(.INDEX_W(INDEX_W), .TAG_W(TAG_W), .DATA_W(DATA_W)) u_store (
    .clk     (clk),
    .tag_we  (tag_we),
    .data_we (data_we),
    .widx    (widx),
    .wtag    (wtag),
    .wdata   (wdata),
    .ridx    (cpu_addr[IDX_LSB +: INDEX_W]),
    .rtag    (rd_tag),
    .rdata   (rd_data)
  );

  assign lane_src = (state_q == ST_MEM) ? mem_rdata : rd_data;

  wtc_lanes #(.DATA_W(DATA_W)) u_lanes (
    .word_in (lane_src),
    .off     (req_addr_q[OFF_W-1:0]),
    .size    (size_e'(req_size_q)),
    .st_data (req_wdata_q),
    .ld_lane (ld_lane),
    .st_be   (st_be),
    .st_rep  (st_rep)
  );

  // The empty code never counts as a match, even for addresses whose tag field is all ones.
  assign hit = cacheable && !req_we_q && (rd_tag == req_tag) && (rd_tag != EMPTY_TAG);

  always_comb begin
    tag_we  = 1'b0;
    data_we = 1'b0;
    widx    = req_idx;
    wtag    = req_tag;
    wdata   = mem_rdata;
    if (state_q == ST_INIT) begin
      tag_we = 1'b1;
      widx   = sweep_q;
      wtag   = EMPTY_TAG;
    end else if (state_q == ST_MEM && mem_ack && cacheable) begin
      tag_we = 1'b1;
      if (!req_we_q) begin
        data_we = 1'b1;
      end else if (req_size_q[1]) begin
        data_we = 1'b1;
        wdata   = req_wdata_q;
      end else begin
        wtag = EMPTY_TAG;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_INIT;
      sweep_q     <= '0;
      req_addr_q  <= '0;
      req_we_q    <= 1'b0;
      req_size_q  <= '0;
      req_wdata_q <= '0;
      cpu_ready   <= 1'b0;
      cpu_rdata   <= '0;
      mem_req     <= 1'b0;
      mem_we      <= 1'b0;
      mem_addr    <= '0;
      mem_be      <= '0;
      mem_wdata   <= '0;
    end else begin
      cpu_ready <= 1'b0;
      case (state_q)
        ST_INIT: begin
          sweep_q <= sweep_q + 1'b1;
          if (sweep_q == INDEX_W'(DEPTH - 1)) state_q <= ST_IDLE;
        end
        ST_IDLE: begin
          if (cpu_req) begin
            req_addr_q  <= cpu_addr;
            req_we_q    <= cpu_we;
            req_size_q  <= cpu_size;
            req_wdata_q <= cpu_wdata;
            state_q     <= ST_LOOK;
          end
        end
        ST_LOOK: begin
          if (hit) begin
            cpu_rdata <= ld_lane;
            cpu_ready <= 1'b1;
            state_q   <= ST_IDLE;
          end else begin
            mem_req   <= 1'b1;
            mem_we    <= req_we_q;
            mem_addr  <= {req_addr_q[ADDR_W-1:OFF_W], {OFF_W{1'b0}}};
            mem_be    <= req_we_q ? st_be : '1;
            mem_wdata <= st_rep;
            state_q   <= ST_MEM;
          end
        end
        ST_MEM: begin
          if (mem_ack) begin
            mem_req   <= 1'b0;
            cpu_ready <= 1'b1;
            if (!req_we_q) cpu_rdata <= ld_lane;
            state_q   <= ST_IDLE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/wtc_checker.sv
module wtc_checker #(
  parameter int ADDR_W = 32,
  parameter int DATA_W = 32,
  parameter int DEPTH  = 1024,
  localparam int LANES = DATA_W / 8,
  localparam int OFF_W = $clog2(LANES),
  localparam int CNT_W = $clog2(DEPTH) + 2
) (
  input logic              clk,
  input logic              rst,
  input logic              cpu_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [LANES-1:0]  mem_be,
  input logic [DATA_W-1:0] mem_wdata,
  input logic              mem_ack
);
  logic [CNT_W-1:0] since_rst;

  always_ff @(posedge clk) begin
    if (rst) since_rst <= '0;
    else if (since_rst != CNT_W'(DEPTH + 1)) since_rst <= since_rst + 1'b1;
  end

  p_sweep_quiet_r1: assert property (@(posedge clk) disable iff (rst)
    (since_rst <= CNT_W'(DEPTH)) |-> !cpu_ready);

  p_word_aligned_r3: assert property (@(posedge clk) disable iff (rst)
    mem_req |-> (mem_addr[OFF_W-1:0] == '0));

  p_fill_all_lanes_r3: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_we) |-> (mem_be == '1));

  p_store_enables_r7: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_we) |->
      ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == LANES));

  p_hold_until_ack_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr) && $stable(mem_we)
                               && $stable(mem_be) && $stable(mem_wdata)));

  p_ack_completes_r10: assert property (@(posedge clk) disable iff (rst)
    (mem_req && mem_ack) |=> (!mem_req && cpu_ready));

  p_ready_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    cpu_ready |=> !cpu_ready);
endmodule

bind wt_line_cache wtc_checker #(
  .ADDR_W (ADDR_W),
  .DATA_W (DATA_W),
  .DEPTH  (DEPTH)
) u_wtc_checker (
  .clk       (clk),
  .rst       (rst),
  .cpu_ready (cpu_ready),
  .mem_req   (mem_req),
  .mem_we    (mem_we),
  .mem_addr  (mem_addr),
  .mem_be    (mem_be),
  .mem_wdata (mem_wdata),
  .mem_ack   (mem_ack)
);

// File: tb/test_wt_line_cache.sv
`timescale 1ns/1ps
module test_wt_line_cache;
  localparam int LINES = 1024;

  logic        clk = 1'b0;
  logic        rst;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [1:0]  cpu_size = 2'd2;
  logic [31:0] cpu_addr = '0, cpu_wdata = '0;
  logic        cpu_ready;
  logic [31:0] cpu_rdata;
  logic        mem_req, mem_we;
  logic [31:0] mem_addr, mem_wdata;
  logic [3:0]  mem_be;
  logic        mem_ack = 1'b0;
  logic [31:0] mem_rdata = '0;

  int checks = 0, fails = 0;
  int rd_cnt = 0, wr_cnt = 0, mem_lat = 1;
  logic [31:0] last_addr, last_wdata;
  logic [3:0]  last_be;
  logic [31:0] backing [logic [31:0]];

  always #4 clk = ~clk;

  wt_line_cache i_wt_line_cache (
    .clk(clk), .rst(rst),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_size(cpu_size),
    .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_ready(cpu_ready), .cpu_rdata(cpu_rdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata),
    .mem_ack(mem_ack), .mem_rdata(mem_rdata)
  );

  function automatic logic [31:0] pat(input logic [31:0] a);
    return {a[15:0] ^ 16'h5A3C, a[31:16] ^ 16'hC3A5};
  endfunction

  function automatic logic [31:0] mem_word(input logic [31:0] a);
    return backing.exists(a) ? backing[a] : pat(a);
  endfunction

  // Memory model: acks after mem_lat cycles, merges writes by byte enable.
  initial begin
    int waited = 0;
    forever begin
      @(negedge clk);
      if (mem_ack) mem_ack = 1'b0;
      else if (mem_req) begin
        waited++;
        if (waited >= mem_lat) begin
          waited = 0;
          last_addr = mem_addr;
          if (mem_we) begin
            logic [31:0] w;
            w = mem_word(mem_addr);
            for (int k = 0; k < 4; k++)
              if (mem_be[k]) w[8*k +: 8] = mem_wdata[8*k +: 8];
            backing[mem_addr] = w;
            last_be = mem_be;
            last_wdata = mem_wdata;
            wr_cnt++;
          end else begin
            mem_rdata = mem_word(mem_addr);
            rd_cnt++;
          end
          mem_ack = 1'b1;
        end
      end
    end
  end

  task automatic expect_eq(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic cpu_op(input logic we, input logic [1:0] sz, input logic [31:0] a,
                        input logic [31:0] wd, output logic [31:0] rd, output int cyc);
    cpu_req = 1'b1; cpu_we = we; cpu_size = sz; cpu_addr = a; cpu_wdata = wd;
    cyc = 0; rd = '0;
    forever begin
      @(negedge clk);
      cyc++;
      if (cpu_ready) begin rd = cpu_rdata; break; end
      if (cyc > 5000) break;
    end
    cpu_req = 1'b0;
  endtask

  task automatic t_reset_sweep;
    logic [31:0] d; int c, r0;
    expect_eq("R1 reset ready", 32'(cpu_ready), 32'd0);
    expect_eq("R1 reset mem_req", 32'(mem_req), 32'd0);
    rst = 1'b0;
    r0 = rd_cnt;
    cpu_op(1'b0, 2'd2, 32'h1000_0040, '0, d, c);
    expect_eq("R1 completes after sweep", 32'(c), 32'(LINES + 3));
    expect_eq("R1 first read misses", 32'(rd_cnt - r0), 32'd1);
    expect_eq("R1 data", d, pat(32'h1000_0040));
  endtask

  task automatic t_miss_then_hit;
    logic [31:0] d; int c, r0;
    mem_lat = 3;
    r0 = rd_cnt;
    cpu_op(1'b0, 2'd2, 32'h1000_0100, '0, d, c);
    expect_eq("R10 miss latency", 32'(c), 32'd5);
    expect_eq("R3 miss reads memory", 32'(rd_cnt - r0), 32'd1);
    expect_eq("R3 aligned fetch", last_addr, 32'h1000_0100);
    expect_eq("R3 miss data", d, pat(32'h1000_0100));
    cpu_op(1'b0, 2'd2, 32'h1000_0100, '0, d, c);
    expect_eq("R3 hit no access", 32'(rd_cnt - r0), 32'd1);
    expect_eq("R10 hit latency", 32'(c), 32'd2);
    expect_eq("R3 hit data", d, pat(32'h1000_0100));
    mem_lat = 1;
  endtask

  task automatic t_lanes;
    logic [31:0] d, w; int c, r0;
    w = pat(32'h1000_0100);
    r0 = rd_cnt;
    for (int k = 0; k < 4; k++) begin
      cpu_op(1'b0, 2'd0, 32'h1000_0100 + 32'(k), '0, d, c);
      expect_eq("R6 byte lane", d, (w >> (8 * (3 - k))) & 32'hFF);
    end
    cpu_op(1'b0, 2'd1, 32'h1000_0100, '0, d, c);
    expect_eq("R6 half lane 0", d, {16'h0, w[31:16]});
    cpu_op(1'b0, 2'd1, 32'h1000_0102, '0, d, c);
    expect_eq("R6 half lane 2", d, {16'h0, w[15:0]});
    expect_eq("R6 sub-word reads hit", 32'(rd_cnt - r0), 32'd0);
  endtask

  task automatic t_regions;
    logic [31:0] d; int c, r0;
    r0 = rd_cnt;
    cpu_op(1'b0, 2'd2, 32'h2000_0100, '0, d, c);
    cpu_op(1'b0, 2'd2, 32'h2000_0100, '0, d, c);
    expect_eq("R2 outside window always reads", 32'(rd_cnt - r0), 32'd2);
    r0 = rd_cnt;
    cpu_op(1'b0, 2'd2, 32'h1020_0100, '0, d, c);
    cpu_op(1'b0, 2'd2, 32'h1020_0100, '0, d, c);
    expect_eq("R2 page 0x102 not cached", 32'(rd_cnt - r0), 32'd2);
    r0 = rd_cnt;
    cpu_op(1'b0, 2'd2, 32'h1010_0200, '0, d, c);
    cpu_op(1'b0, 2'd2, 32'h1010_0200, '0, d, c);
    expect_eq("R2 page 0x101 cached", 32'(rd_cnt - r0), 32'd1);
    expect_eq("R2 page 0x101 data", d, pat(32'h1010_0200));
  endtask

  task automatic t_index_tag;
    logic [31:0] d; int c, r0;
    r0 = rd_cnt;
    cpu_op(1'b0, 2'd2, 32'h1000_0300, '0, d, c);
    cpu_op(1'b0, 2'd2, 32'h1000_1300, '0, d, c);
    cpu_op(1'b0, 2'd2, 32'h1000_0300, '0, d, c);
    expect_eq("R4 same index evicts", 32'(rd_cnt - r0), 32'd3);
    expect_eq("R4 refetched data", d, pat(32'h1000_0300));
    r0 = rd_cnt;
    cpu_op(1'b0, 2'd2, 32'h1010_0300, '0, d, c);
    cpu_op(1'b0, 2'd2, 32'h1000_0300, '0, d, c);
    expect_eq("R4 tag bit 20 distinguishes", 32'(rd_cnt - r0), 32'd2);
    r0 = rd_cnt;
    cpu_op(1'b0, 2'd2, 32'h101F_F400, '0, d, c);
    cpu_op(1'b0, 2'd2, 32'h101F_F400, '0, d, c);
    expect_eq("R5 all-ones tag never hits", 32'(rd_cnt - r0), 32'd2);
  endtask

  task automatic t_word_write;
    logic [31:0] d; int c, r0, w0;
    r0 = rd_cnt; w0 = wr_cnt;
    cpu_op(1'b1, 2'd2, 32'h1000_0500, 32'hDEAD_BEEF, d, c);
    expect_eq("R7 word write reaches memory", 32'(wr_cnt - w0), 32'd1);
    expect_eq("R7 word enables", 32'(last_be), 32'hF);
    cpu_op(1'b0, 2'd2, 32'h1000_0500, '0, d, c);
    expect_eq("R8 read after word write hits", 32'(rd_cnt - r0), 32'd0);
    expect_eq("R8 written data", d, 32'hDEAD_BEEF);
  endtask

  task automatic t_partial_write;
    logic [31:0] d, w; int c, r0, w0;
    cpu_op(1'b0, 2'd2, 32'h1000_0600, '0, d, c);
    w = pat(32'h1000_0600);
    w0 = wr_cnt;
    cpu_op(1'b1, 2'd0, 32'h1000_0601, 32'h0000_00AB, d, c);
    expect_eq("R7 byte write reaches memory", 32'(wr_cnt - w0), 32'd1);
    expect_eq("R7 byte enable offset 1", 32'(last_be), 32'b0100);
    expect_eq("R7 byte replicated", last_wdata, 32'hABAB_ABAB);
    expect_eq("R7 word address", last_addr, 32'h1000_0600);
    r0 = rd_cnt;
    cpu_op(1'b0, 2'd2, 32'h1000_0600, '0, d, c);
    expect_eq("R9 byte write invalidates", 32'(rd_cnt - r0), 32'd1);
    expect_eq("R9 merged data", d, {w[31:24], 8'hAB, w[15:0]});
    cpu_op(1'b1, 2'd1, 32'h1000_0602, 32'h0000_1234, d, c);
    expect_eq("R7 half enable offset 2", 32'(last_be), 32'b0011);
    expect_eq("R7 half replicated", last_wdata, 32'h1234_1234);
    r0 = rd_cnt;
    cpu_op(1'b0, 2'd2, 32'h1000_0600, '0, d, c);
    expect_eq("R9 half write invalidates", 32'(rd_cnt - r0), 32'd1);
    expect_eq("R9 half merged", d, {w[31:24], 8'hAB, 16'h1234});
  endtask

  task automatic t_bypass_write;
    logic [31:0] d, v; int c, r0, w0;
    cpu_op(1'b0, 2'd2, 32'h1000_0700, '0, v, c);
    w0 = wr_cnt;
    cpu_op(1'b1, 2'd2, 32'h2000_0700, 32'h1111_2222, d, c);
    expect_eq("R11 bypass write reaches memory", 32'(wr_cnt - w0), 32'd1);
    r0 = rd_cnt;
    cpu_op(1'b0, 2'd2, 32'h1000_0700, '0, d, c);
    expect_eq("R11 cached line still hits", 32'(rd_cnt - r0), 32'd0);
    expect_eq("R11 cached data unchanged", d, v);
    cpu_op(1'b0, 2'd2, 32'h2000_0700, '0, d, c);
    expect_eq("R11 bypass read sees write", d, 32'h1111_2222);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; fails++;
    $display("FAIL R10 watchdog: actual hung expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    rst = 1'b1;
    repeat (4) @(negedge clk);
    t_reset_sweep();
    t_miss_then_hit();
    t_lanes();
    t_regions();
    t_index_tag();
    t_word_write();
    t_partial_write();
    t_bypass_write();
    repeat (3) @(negedge clk);
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule